// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter with Coherent Byte Reads

This block is a free-running 16-bit up-counter. It advances once for each enable pulse from a clock-source selector. A 3-bit select field in a small control register chooses the source. It can be one of seven power-of-two divisions of the bus clock, taken from a 6-bit prescaler. It can also be the rising edges of an external clock pin, which first pass through a synchronizer. A timer-reset bit in the same register clears the counter and the prescaler in a single cycle.

The count is read over an 8-bit bus with two strobes, one for each byte. Reading the upper byte first captures the lower byte into a buffer, so the two reads together give the count at a single instant. The buffer stays armed through any number of further upper-byte reads. Only a lower-byte read releases it, whether or not the core is halted for debugging. Address decoding, compare and capture channels, and interrupts belong to the surrounding logic.

Top module: `tmr16_prescaled`

## Requirements
- R1: Select codes 0 to 6 divide the bus clock by 2^code. Take a write that sets timer-reset together with code k, and count the clock edges from that write onward. After N such edges with the code unchanged, the count equals floor(N / 2^k).
- R2: Select code 7 advances the count once for each rising edge of `ext_clk`, after a two-flop synchronizer. A level that is held, high or low, adds nothing. The pin must toggle at less than half the bus clock rate.
- R3: The control register holds the select field in bits 2:0 and the timer-reset bit in bit 4. `ctl_rdata` returns the select field in bits 2:0 and zeros in all other bits, so the timer-reset bit always reads 0. Reset sets the select field to 0.
- R4: While `rst_n` is low, the count, the select field and the low-byte buffer are all zero.
- R5: A control write with bit 4 set clears the counter and the prescaler at the clock edge that takes the write. The count is zero from then on until the next enable.
- R6: When `rd_hi` is asserted, `rd_data` shows count bits 15:8. If the buffer is not armed, bits 7:0 are copied into the buffer at that edge and the buffer becomes armed.
- R7: While the buffer is armed, further `rd_hi` reads leave it unchanged.
- R8: When `rd_lo` is asserted, `rd_data` shows the buffer if it is armed, or the live bits 7:0 if it is not. The buffer is disarmed at that edge.
- R9: The count wraps from 0xFFFF to 0x0000. In each cycle it changes by at most one.
- R10: A select write without timer-reset leaves the count unchanged. The edge that takes the write still uses the old source, and the new source applies from the following edge.
- R11: With no read strobe, `rd_data` is 0. If `rd_hi` and `rd_lo` are both asserted, `rd_data` shows the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bits 2:0 select, bit 4 timer-reset |
| ctl_rdata | output | 8 | Control readback: the select field, zero-extended |
| ext_clk | input | 1 | External clock pin, asynchronous |
| rd_hi | input | 1 | Upper count byte read strobe |
| rd_lo | input | 1 | Lower count byte read strobe |
| rd_data | output | 8 | Read data for the active strobe |

## Verification
The bench first freezes the counter by switching to the external source with the pin idle. It then checks each divider ratio against floor(N / 2^k) exactly, so a prescaler that is off by one edge or uses the wrong mask shows up as a different count. The latch test reads the upper byte twice 10 cycles apart while the counter runs at full rate, and then reads the lower byte. A design that reloads the buffer on every upper-byte read returns 0x04 here instead of 0xFA. A later lower-byte read with no preceding upper-byte read must return the live byte, which catches a latch that never releases. The wrap check runs through 0xFFFF, and the select-change check confirms the count carries on from its frozen value rather than restarting.

// File: rtl/tmr16_prescaled.sv
module tmr16_prescaled #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3,
  parameter int CLR_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [BUS_W-1:0] ctl_wdata,
  output logic [BUS_W-1:0] ctl_rdata,
  input  logic             ext_clk,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [BUS_W-1:0] rd_data
);
  localparam int EXT_CODE = (1 << SEL_W) - 1;
  localparam int DIV_W    = EXT_CODE - 1;

  logic [SEL_W-1:0] sel;
  logic [DIV_W-1:0] div, div_mask;
  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] lo_buf;
  logic             armed;
  logic [2:0]       ext_s;
  logic             ext_rise, presc_tick, tick, clr;

  wire unused_wbits = ^{ctl_wdata[BUS_W-1:CLR_BIT+1], ctl_wdata[CLR_BIT-1:SEL_W]};

  assign clr = ctl_we & ctl_wdata[CLR_BIT];

  always_comb begin
    for (int i = 0; i < DIV_W; i++) div_mask[i] = (i < int'(sel));
  end

  assign presc_tick = (div & div_mask) == div_mask;
  assign ext_rise   = ext_s[1] & ~ext_s[2];
  assign tick       = (sel == SEL_W'(EXT_CODE)) ? ext_rise : presc_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
    end else if (ctl_we) begin
      sel <= ctl_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_s <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      div <= '0;
      cnt <= '0;
    end else begin
      div <= div + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      lo_buf <= '0;
    end else if (rd_lo) begin
      armed <= 1'b0;
    end else if (rd_hi && !armed) begin
      armed  <= 1'b1;
      lo_buf <= cnt[BUS_W-1:0];
    end
  end

  assign ctl_rdata = {{(BUS_W-SEL_W){1'b0}}, sel};
  assign rd_data   = rd_hi ? cnt[CNT_W-1:BUS_W]
                   : rd_lo ? (armed ? lo_buf : cnt[BUS_W-1:0])
                   : '0;
endmodule

module tmr16_prescaled_chk #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             ctl_we,
  input logic [SEL_W-1:0] wsel,
  input logic [SEL_W-1:0] sel,
  input logic             rd_hi,
  input logic             rd_lo,
  input logic [CNT_W-1:0] cnt,
  input logic             armed,
  input logic [BUS_W-1:0] lo_buf,
  input logic             tick,
  input logic             ext_rise
);
  localparam logic [SEL_W-1:0] SLOWEST = SEL_W'((1 << SEL_W) - 2);

  assert_div_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SLOWEST && !ctl_we && tick) |=> !tick);
  assert_ext_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
  assert_sel_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> sel == $past(wsel));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_hi && !rd_lo) |=> $stable(lo_buf) && armed);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !armed);
  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

bind tmr16_prescaled tmr16_prescaled_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ctl_we(ctl_we), .wsel(ctl_wdata[SEL_W-1:0]),
  .sel(sel), .rd_hi(rd_hi), .rd_lo(rd_lo), .cnt(cnt), .armed(armed),
  .lo_buf(lo_buf), .tick(tick), .ext_rise(ext_rise));

// File: tb/tmr16_prescaled_tb.sv
module tmr16_prescaled_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       ext_clk = 1'b0;
  logic       rd_hi = 1'b0;
  logic       rd_lo = 1'b0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int j = 0;

  typedef struct { logic [7:0] v; string t; } exp_t;
  exp_t q[$];

  tmr16_prescaled u_dut (.*);

  always #5ns clk = ~clk;

  always @(negedge clk) begin
    #2ns;
    if (rd_hi || rd_lo) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: rd_data=%h expected none", rd_data);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rd_data !== e.v) begin
          n_fail++;
          $display("FAIL %s: rd_data=%h expected %h", e.t, rd_data, e.v);
        end
      end
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected %h", t, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    j += n;
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step(1);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic ctl_clear(input int k);
    ctl_write(8'h10 | 8'(k));
    j = 0;
  endtask

  task automatic push(input logic [7:0] v, input string t);
    exp_t e;
    e.v = v; e.t = t;
    q.push_back(e);
  endtask

  task automatic read16(input int v, input string t);
    push(8'((v >> 8) & 255), t);
    rd_hi = 1'b1; step(1); rd_hi = 1'b0;
    push(8'(v & 255), t);
    rd_lo = 1'b1; step(1); rd_lo = 1'b0;
  endtask

  task automatic run_div(input int k, input int n);
    ctl_clear(k);
    step(n - 1);
    ctl_write(8'h07);
    read16((n >> k) & 16'hFFFF, "R1");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1500us;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected completion");
    finish_run();
  end

  initial begin
    step(2);
    #2ns;
    check(ctl_rdata, 8'h00, "R3 reset select");
    check(rd_data, 8'h00, "R11 idle");
    push(8'h00, "R4"); rd_hi = 1'b1; step(1); rd_hi = 1'b0;
    push(8'h00, "R4"); rd_lo = 1'b1; step(1); rd_lo = 1'b0;
    rst_n = 1'b1;
    step(1);

    // R1: every divider ratio, counter frozen afterwards on idle ext pin
    run_div(0, 300);
    push(8'h01, "R11 both strobes"); rd_hi = 1'b1; rd_lo = 1'b1; step(1);
    rd_hi = 1'b0; rd_lo = 1'b0;
    run_div(1, 301);
    run_div(2, 1003);
    run_div(3, 2049);
    run_div(4, 4000);
    run_div(5, 70);
    run_div(6, 1000);

    // R10: switch to divide-by-1 without clearing; count continues from 15
    ctl_write(8'h00);
    j = 0;
    step(20);
    read16(15 + 20, "R10");

    // R5 and R3: clear while running, timer-reset bit reads back 0
    ctl_write(8'h17);
    #2ns;
    check(ctl_rdata, 8'h07, "R3 readback");
    read16(0, "R5");
    ctl_write(8'h15);
    #2ns;
    check(ctl_rdata, 8'h05, "R3 readback");

    // R2: external clock edges
    ctl_clear(7);
    for (int p = 0; p < 5; p++) begin
      ext_clk = 1'b1; step(2);
      ext_clk = 1'b0; step(2);
    end
    step(4);
    read16(5, "R2");
    ext_clk = 1'b1; step(10);
    read16(6, "R2");
    ext_clk = 1'b0; step(4);

    // R6, R7, R8: latch behaviour at full rate
    ctl_clear(0);
    step(250);
    push(8'h00, "R6"); rd_hi = 1'b1; step(1); rd_hi = 1'b0;
    step(9);
    push(8'h01, "R7"); rd_hi = 1'b1; step(1); rd_hi = 1'b0;
    step(9);
    push(8'hFA, "R7"); rd_lo = 1'b1; step(1); rd_lo = 1'b0;
    step(9);
    push(8'h18, "R8"); rd_lo = 1'b1; step(1); rd_lo = 1'b0;
    #2ns;
    check(rd_data, 8'h00, "R11 idle");

    // R9: wrap through 0xFFFF
    ctl_clear(0);
    step(65535);
    read16(16'hFFFF, "R9");
    read16(1, "R9");

    step(2);
    check(8'(q.size()), 8'h00, "scoreboard drained");
    finish_run();
  end
endmodule